// File: doc/BRIEF.md
# External Interrupt Cause Flag Unit

This block watches eight external interrupt pins and turns chosen pin conditions into stored cause flags. Each pin first passes through a multi-flop synchroniser. A 2-bit selector per channel then picks one of four conditions: low level, high level, rising edge or falling edge. When the selected condition is seen, the channel's cause flag is latched, and it stays set until something clears it.

Software reads the eight flags on a read bus. A write clears a flag only where the written bit is 0. A write bit of 1 leaves that flag as it was. A data-transfer service engine can clear a single channel with a one-cycle acknowledge once it has moved one datum. A per-channel enable gates each flag onto one combined interrupt request. Because a flag also latches while its channel is disabled, software clears the flag right before it sets the enable.

Top module: `extint_flag_unit`

## Requirements
- R1: With selector 01 (high level), a high pin sets the channel flag. A pin change driven between two rising clock edges appears on the flag read bus after the third following rising edge, and not after the second (default of two synchroniser stages).
- R2: With selector 00 (low level), a low synchronised pin sets the channel flag at the next rising edge.
- R3: With selector 10 (rising edge), a 0-to-1 transition sets the flag exactly once. A pin that stays high afterwards does not set it again, and a 1-to-0 transition does not set it.
- R4: With selector 11 (falling edge), a 1-to-0 transition sets the flag, and a 0-to-1 transition does not.
- R5: A flag write clears each flag whose write-data bit is 0. Write-data bits of 1 leave their flags unchanged, and writing all ones changes nothing.
- R6: A one-cycle service acknowledge on a channel (bit i of the acknowledge vector) clears that channel's flag only.
- R7: If a detection event and a clear (a write of 0 or an acknowledge) hit the same channel in the same cycle, the flag ends up set.
- R8: A flag latches even while its enable bit is 0, and a flag with a 0 enable never raises the request.
- R9: The request output is high exactly when some channel has both its flag and its enable at 1. It follows enable changes within the same cycle.
- R10: In level mode, the flag is set again on every clock while the active level lasts, so a clear takes lasting effect only after the level has gone.
- R11: Reset drives all flags to 0 and the request output low.
- R12: Flags hold their value in any cycle that has no detection event and no clear on their channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pinIn | input | 8 | Asynchronous external interrupt pins, bit i = channel i |
| detSel | input | 16 | Per-channel condition selector, bits [2i+1:2i] for channel i: 00 low, 01 high, 10 rising, 11 falling |
| chanEn | input | 8 | Per-channel request enable |
| flagWrEn | input | 1 | Flag register write strobe |
| flagWrData | input | 8 | Write data; 0 bits clear flags, 1 bits leave them |
| svcAck | input | 8 | One-cycle transfer-service acknowledge per channel; clears that flag |
| flagRdData | output | 8 | Current flag values |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The bench builds the unit with its default values: eight channels and two synchroniser stages. That makes the pin-to-flag latency exactly three edges, so a check one edge early can catch a missing or extra stage. Eight channels leave room to put each selector encoding on its own channel, so modes cannot mask one another. With that room, the bench can also time a detection to land in the same cycle as a write-clear and an acknowledge, and it can hold a level across a clear.

// File: rtl/extint_pkg.sv
package extint_pkg;

  parameter int EXT_CH = 8;

  typedef enum logic [1:0] {
    DET_LOW  = 2'b00,
    DET_HIGH = 2'b01,
    DET_RISE = 2'b10,
    DET_FALL = 2'b11
  } detMode_e;

  typedef struct packed {
    logic [EXT_CH-1:0] setMask;
    logic [EXT_CH-1:0] clrMask;
  } chStrobe_t;

endpackage

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import extint_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [EXT_CH-1:0]     pinIn,
  input  logic [2*EXT_CH-1:0]   detSel,
  input  logic                  flagWrEn,
  input  logic [EXT_CH-1:0]     flagWrData,
  input  logic [EXT_CH-1:0]     svcAck,
  output chStrobe_t             strobe
);

  localparam int NUM_CH  = EXT_CH;
  localparam int LAST_ST = SYNC_STAGES - 1;

  logic [NUM_CH-1:0] syncQ [SYNC_STAGES];
  logic [NUM_CH-1:0] pinPrev;
  logic [NUM_CH-1:0] pinNow;
  logic [NUM_CH-1:0] detHit;
  logic [NUM_CH-1:0] wrClr;

  // synchroniser chain, stage 0 samples the raw pins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ[0] <= '0;
    end else begin
      syncQ[0] <= pinIn;
    end
  end

  generate
    for (genvar st = 1; st < SYNC_STAGES; st++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          syncQ[st] <= '0;
        end else begin
          syncQ[st] <= syncQ[st-1];
        end
      end
    end
  endgenerate

  assign pinNow = syncQ[LAST_ST];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinPrev <= '0;
    end else begin
      pinPrev <= pinNow;
    end
  end

  // per-channel condition decode
  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_det
      detMode_e modeSel;
      assign modeSel = detMode_e'(detSel[2*ch +: 2]);
      always_comb begin
        unique case (modeSel)
          DET_LOW:  detHit[ch] = ~pinNow[ch];
          DET_HIGH: detHit[ch] = pinNow[ch];
          DET_RISE: detHit[ch] = pinNow[ch] & ~pinPrev[ch];
          DET_FALL: detHit[ch] = ~pinNow[ch] & pinPrev[ch];
          default:  detHit[ch] = 1'b0;
        endcase
      end
    end
  endgenerate

  assign wrClr          = flagWrEn ? ~flagWrData : '0;
  assign strobe.setMask = detHit;
  assign strobe.clrMask = wrClr | svcAck;

endmodule

// File: rtl/extint_datapath.sv
module extint_datapath
  import extint_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  chStrobe_t         strobe,
  input  logic [EXT_CH-1:0] chanEn,
  output logic [EXT_CH-1:0] flags,
  output logic              irqOut
);

  localparam int NUM_CH = EXT_CH;

  logic [NUM_CH-1:0] flagsNext;

  // set has priority over clear so no event is lost
  assign flagsNext = (flags & ~strobe.clrMask) | strobe.setMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags <= '0;
    end else begin
      flags <= flagsNext;
    end
  end

  assign irqOut = |(flags & chanEn);

  // R1
  set_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.setMask != '0) |=> ((flags & $past(strobe.setMask)) == $past(strobe.setMask)));

  // R5
  clear_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((strobe.clrMask & ~strobe.setMask) != '0)
      |=> ((flags & $past(strobe.clrMask & ~strobe.setMask)) == '0));

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (((flags ^ $past(flags)) & ~$past(strobe.setMask | strobe.clrMask)) == '0));

  // R8
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((flags & ~$past(flags) & ~$past(strobe.setMask)) == '0));

endmodule

// File: rtl/extint_flag_unit.sv
module extint_flag_unit
  import extint_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [EXT_CH-1:0]   pinIn,
  input  logic [2*EXT_CH-1:0] detSel,
  input  logic [EXT_CH-1:0]   chanEn,
  input  logic                flagWrEn,
  input  logic [EXT_CH-1:0]   flagWrData,
  input  logic [EXT_CH-1:0]   svcAck,
  output logic [EXT_CH-1:0]   flagRdData,
  output logic                irqOut
);

  chStrobe_t strobe;

  extint_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .pinIn      (pinIn),
    .detSel     (detSel),
    .flagWrEn   (flagWrEn),
    .flagWrData (flagWrData),
    .svcAck     (svcAck),
    .strobe     (strobe)
  );

  extint_datapath dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .chanEn (chanEn),
    .flags  (flagRdData),
    .irqOut (irqOut)
  );

  // R9
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> ((flagRdData & chanEn) != '0));

endmodule

// File: tb/extint_flag_unit_tb_top.sv
`timescale 1ns/1ps
module extint_flag_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  pinIn;
  logic [15:0] detSel;
  logic [7:0]  chanEn;
  logic        flagWrEn;
  logic [7:0]  flagWrData;
  logic [7:0]  svcAck;
  logic [7:0]  flagRdData;
  logic        irqOut;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  typedef struct {
    logic [7:0] expFlags;
    logic       expIrq;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];

  always #10 clk = ~clk;

  extint_flag_unit dut_i (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .detSel(detSel), .chanEn(chanEn),
    .flagWrEn(flagWrEn), .flagWrData(flagWrData), .svcAck(svcAck),
    .flagRdData(flagRdData), .irqOut(irqOut)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_state(input logic [7:0] f, input logic irq, input string tag);
    expItem_t it;
    it.expFlags = f;
    it.expIrq   = irq;
    it.tag      = tag;
    expQ.push_back(it);
    #2;
  endtask

  task automatic write_flags(input logic [7:0] d);
    flagWrEn   = 1'b1;
    flagWrData = d;
    tick(1);
    flagWrEn   = 1'b0;
    flagWrData = 8'hFF;
  endtask

  task automatic set_mode(input int ch, input logic [1:0] m);
    detSel[2*ch +: 2] = m;
  endtask

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      wait (expQ.size() != 0);
      #1;
      begin
        expItem_t it;
        it = expQ.pop_front();
        checks++;
        if (flagRdData !== it.expFlags || irqOut !== it.expIrq) begin
          failures++;
          $display("FAIL %s: flags=%h irq=%b expected flags=%h irq=%b",
                   it.tag, flagRdData, irqOut, it.expFlags, it.expIrq);
        end
      end
    end
  end

  initial begin
    #(100000 * 20);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; pinIn = 8'h00; detSel = 16'h5555; chanEn = 8'h00;
    flagWrEn = 1'b0; flagWrData = 8'hFF; svcAck = 8'h00;
    tick(5);
    rstN = 1'b1;
    tick(1);
    expect_state(8'h00, 1'b0, "R11 reset state");

    // R1 high level with latency
    pinIn[0] = 1'b1;
    tick(2);
    expect_state(8'h00, 1'b0, "R1 not yet after two edges");
    tick(1);
    expect_state(8'h01, 1'b0, "R1 high level sets flag, R8 no irq while disabled");
    chanEn = 8'h01;
    expect_state(8'h01, 1'b1, "R9 enable raises irq");

    // R10 level persists across a clear
    write_flags(8'hFE);
    expect_state(8'h01, 1'b1, "R10 clear ignored while level held");
    pinIn[0] = 1'b0;
    tick(3);
    write_flags(8'hFE);
    expect_state(8'h00, 1'b0, "R10 clear effective after level gone");

    // R5 write semantics
    pinIn[2:1] = 2'b11;
    tick(3);
    pinIn[2:1] = 2'b00;
    tick(3);
    expect_state(8'h06, 1'b0, "R8 flags latch while disabled");
    write_flags(8'hFF);
    expect_state(8'h06, 1'b0, "R5 all-ones write no effect");
    write_flags(8'hFB);
    expect_state(8'h02, 1'b0, "R5 zero bit clears only its flag");
    chanEn = 8'h02;
    expect_state(8'h02, 1'b1, "R9 irq from channel 1");
    write_flags(8'hFD);
    expect_state(8'h00, 1'b0, "R5 clear channel 1");

    // R2 low level
    set_mode(3, 2'b00);
    tick(1);
    expect_state(8'h08, 1'b0, "R2 low level sets flag");
    pinIn[3] = 1'b1;
    tick(3);
    write_flags(8'hF7);
    expect_state(8'h00, 1'b0, "R2 clear after level left");

    // R3 rising edge
    set_mode(4, 2'b10);
    pinIn[4] = 1'b1;
    tick(3);
    expect_state(8'h10, 1'b0, "R3 rising edge sets flag");
    write_flags(8'hEF);
    tick(4);
    expect_state(8'h00, 1'b0, "R3 steady high does not re-set");
    pinIn[4] = 1'b0;
    tick(3);
    expect_state(8'h00, 1'b0, "R3 falling edge ignored in rising mode");

    // R4 falling edge
    set_mode(5, 2'b11);
    pinIn[5] = 1'b1;
    tick(3);
    expect_state(8'h00, 1'b0, "R4 rising edge ignored in falling mode");
    pinIn[5] = 1'b0;
    tick(2);
    expect_state(8'h00, 1'b0, "R4 not yet after two edges");
    tick(1);
    expect_state(8'h20, 1'b0, "R4 falling edge sets flag");
    write_flags(8'hDF);
    expect_state(8'h00, 1'b0, "R5 clear channel 5");

    // R6 service acknowledge
    pinIn[5] = 1'b1;
    tick(3);
    pinIn[5] = 1'b0;
    tick(3);
    pinIn[1] = 1'b1;
    tick(3);
    pinIn[1] = 1'b0;
    tick(3);
    expect_state(8'h22, 1'b1, "R6 two flags before acknowledge");
    svcAck = 8'h20;
    tick(1);
    svcAck = 8'h00;
    expect_state(8'h02, 1'b1, "R6 acknowledge clears only its channel");
    write_flags(8'hFD);

    // R7 set wins over simultaneous clears
    pinIn[4] = 1'b1;
    tick(2);
    flagWrEn = 1'b1; flagWrData = 8'hEF; svcAck = 8'h10;
    tick(1);
    flagWrEn = 1'b0; flagWrData = 8'hFF; svcAck = 8'h00;
    expect_state(8'h10, 1'b0, "R7 set wins over same-cycle clear");
    write_flags(8'hEF);
    expect_state(8'h00, 1'b0, "R7 later clear works");

    // R9 / R8 multi-channel request
    pinIn[7:6] = 2'b11;
    tick(3);
    pinIn[7:6] = 2'b00;
    tick(3);
    chanEn = 8'h80;
    expect_state(8'hC0, 1'b1, "R9 irq with one of two enabled");
    chanEn = 8'h3F;
    expect_state(8'hC0, 1'b0, "R8 flags without enable give no irq");
    write_flags(8'h00);
    expect_state(8'h00, 1'b0, "R5 all-zero write clears all");

    wait (expQ.size() == 0);
    #5;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule